// File: doc/BRIEF.md
# Component control state unit

This unit sits beside one memory-system component (a cache, a translation buffer, a remote-access engine) and decides, cycle by cycle, whether that component may take in new requests and whether it may send responses. A controller steers it through a single command port with seven commands: enable, disable, pause, resume, and three memory actions (drain, flush, invalidate). The unit holds the enable, pause and busy-action state. It counts the requests the component has taken but not yet retired, and it raises a one-cycle general response when each command completes.

Enable, disable, pause and resume take effect, and respond, on the clock edge that samples them. Drain waits until every taken request has retired. Flush waits for a done pulse from the component. Invalidate raises a buffer-clear pulse for one cycle, zeroes the count and responds on the next edge. A command that breaks the sequencing rules changes nothing and sets a sticky error flag.

Top module: `comp_ctrl_unit`

## Requirements
- R1: After reset the unit is disabled and unpaused with no action in progress and a zero count: acceptEn, respondEn, clearBuf, rspValid and errFlag are all 0.
- R2: Command codes on cmdOp are 0 enable, 1 disable, 2 pause, 3 resume and 4 memory action; codes 5 to 7 are illegal. A legal enable makes acceptEn and respondEn 1, clears pause, and gives rspValid for one cycle with rspKind 0 on the edge that samples it. An enable while already enabled is illegal.
- R3: While disabled, every command except enable is illegal. A disable is legal only while enabled. It makes acceptEn and respondEn 0 and responds at once with rspKind 1.
- R4: Pause (rspKind 2) and resume (rspKind 3) respond on the sampling edge. While paused, acceptEn and respondEn are 0, and later commands are still carried out. acceptEn is never 1 while respondEn is 0.
- R5: For a memory action, cmdAct bit 0 selects drain, bit 1 flush and bit 2 invalidate. During a drain, acceptEn is 0 and respondEn keeps its value. On the first edge at which the outstanding count (reqTaken increments it, reqDone decrements it) is zero, the unit returns to idle with rspKind 4. That response therefore comes one edge after the last reqDone.
- R6: During a flush, acceptEn is 0. The first flushDone sampled during the flush ends it with rspKind 5. A flushDone sampled at any other time has no effect.
- R7: An invalidate makes clearBuf 1 for exactly the next cycle, with acceptEn and respondEn 0. The following edge zeroes the outstanding count and responds with rspKind 6.
- R8: A memory action whose cmdAct does not have exactly one bit set (for example drain together with flush) is illegal.
- R9: Any command sampled while a drain, flush or invalidate is in progress is illegal. A command sampled in the cycle in which that action's response is visible is accepted.
- R10: An illegal command changes no state and gives no response. It sets errFlag, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Command code |
| cmdAct | input | 3 | Memory action select: bit 0 drain, bit 1 flush, bit 2 invalidate |
| reqTaken | input | 1 | The component took one request this cycle |
| reqDone | input | 1 | The component retired one taken request this cycle |
| flushDone | input | 1 | The component finished its flush |
| acceptEn | output | 1 | The component may take new requests |
| respondEn | output | 1 | The component may send responses |
| clearBuf | output | 1 | One-cycle pulse: discard all buffered requests and responses |
| rspValid | output | 1 | General response, one cycle per completed command |
| rspKind | output | 3 | Completed command: 0 enable, 1 disable, 2 pause, 3 resume, 4 drain, 5 flush, 6 invalidate |
| errFlag | output | 1 | Sticky illegal-command flag |

## Verification
The assertions assume that the component raises reqTaken only while acceptEn is 1, and raises reqDone only when it holds at least one taken request. Under that assumption the count can neither wrap nor go negative. They also assume that reset is applied before any check matters. The stimulus keeps a count of the requests in flight. It raises reqTaken only in cycles where the enable, pause and action state allows intake, and reqDone only while that count is positive. flushDone pulses both inside and outside a flush, because a pulse outside a flush is defined to have no effect.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int OP_W   = 3;
  localparam int ACT_W  = 3;
  localparam int KIND_W = 3;

  localparam logic [OP_W-1:0] OP_ENABLE  = 3'd0;
  localparam logic [OP_W-1:0] OP_DISABLE = 3'd1;
  localparam logic [OP_W-1:0] OP_PAUSE   = 3'd2;
  localparam logic [OP_W-1:0] OP_RESUME  = 3'd3;
  localparam logic [OP_W-1:0] OP_MEM     = 3'd4;

  localparam int ACT_DRAIN = 0;
  localparam int ACT_FLUSH = 1;
  localparam int ACT_INVAL = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_ENABLE  = 3'd0,
    KIND_DISABLE = 3'd1,
    KIND_PAUSE   = 3'd2,
    KIND_RESUME  = 3'd3,
    KIND_DRAIN   = 3'd4,
    KIND_FLUSH   = 3'd5,
    KIND_INVAL   = 3'd6
  } rsp_kind_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_DRAIN = 2'd1,
    MODE_FLUSH = 2'd2,
    MODE_INVAL = 2'd3
  } act_mode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic      rspFire;
    rsp_kind_e rspKind;
    logic      errSet;
    logic      clrStart;
    logic      cntClear;
  } ccu_strobe_t;

  // decoded command
  typedef struct packed {
    logic goEnable;
    logic goDisable;
    logic goPause;
    logic goResume;
    logic goDrain;
    logic goFlush;
    logic goInval;
    logic badCmd;
  } ccu_dec_t;

endpackage

// File: rtl/ccu_decode.sv
module ccu_decode
  import ccu_pkg::*;
(
  input  logic             cmdValid,
  input  logic [OP_W-1:0]  cmdOp,
  input  logic [ACT_W-1:0] cmdAct,
  input  logic             enabled,
  input  logic             busy,
  output ccu_dec_t         dec
);

  logic actOne;
  assign actOne = $onehot(cmdAct);

  always_comb begin
    dec = '0;
    if (cmdValid) begin
      if (busy) begin
        dec.badCmd = 1'b1;                 // R9
      end else if (!enabled) begin
        if (cmdOp == OP_ENABLE) dec.goEnable = 1'b1;
        else                    dec.badCmd   = 1'b1;  // R3
      end else begin
        case (cmdOp)
          OP_ENABLE:  dec.badCmd    = 1'b1;  // R2 re-enable
          OP_DISABLE: dec.goDisable = 1'b1;
          OP_PAUSE:   dec.goPause   = 1'b1;
          OP_RESUME:  dec.goResume  = 1'b1;
          OP_MEM: begin
            if (!actOne)                dec.badCmd  = 1'b1;  // R8
            else if (cmdAct[ACT_DRAIN]) dec.goDrain = 1'b1;
            else if (cmdAct[ACT_FLUSH]) dec.goFlush = 1'b1;
            else                        dec.goInval = 1'b1;
          end
          default:    dec.badCmd    = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ccu_dec_t    dec,
  input  logic        cntZero,
  input  logic        flushDone,
  output logic        enabled,
  output logic        busy,
  output logic        acceptEn,
  output logic        respondEn,
  output ccu_strobe_t stb
);

  logic      paused;
  act_mode_e mode;
  logic      nEnabled, nPaused;
  act_mode_e nMode;

  always_comb begin
    stb      = '0;
    nEnabled = enabled;
    nPaused  = paused;
    nMode    = mode;

    // completion of an action in progress
    case (mode)
      MODE_DRAIN: if (cntZero) begin
        stb.rspFire = 1'b1;
        stb.rspKind = KIND_DRAIN;
        nMode       = MODE_IDLE;
      end
      MODE_FLUSH: if (flushDone) begin
        stb.rspFire = 1'b1;
        stb.rspKind = KIND_FLUSH;
        nMode       = MODE_IDLE;
      end
      MODE_INVAL: begin
        stb.rspFire  = 1'b1;
        stb.rspKind  = KIND_INVAL;
        stb.cntClear = 1'b1;
        nMode        = MODE_IDLE;
      end
      default: ;
    endcase

    // new commands (decoder rejects everything while busy)
    if (dec.goEnable) begin
      nEnabled    = 1'b1;
      nPaused     = 1'b0;
      stb.rspFire = 1'b1;
      stb.rspKind = KIND_ENABLE;
    end
    if (dec.goDisable) begin
      nEnabled    = 1'b0;
      nPaused     = 1'b0;
      stb.rspFire = 1'b1;
      stb.rspKind = KIND_DISABLE;
    end
    if (dec.goPause) begin
      nPaused     = 1'b1;
      stb.rspFire = 1'b1;
      stb.rspKind = KIND_PAUSE;
    end
    if (dec.goResume) begin
      nPaused     = 1'b0;
      stb.rspFire = 1'b1;
      stb.rspKind = KIND_RESUME;
    end
    if (dec.goDrain) nMode = MODE_DRAIN;
    if (dec.goFlush) nMode = MODE_FLUSH;
    if (dec.goInval) begin
      nMode        = MODE_INVAL;
      stb.clrStart = 1'b1;
    end
    if (dec.badCmd) stb.errSet = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b0;
      paused  <= 1'b0;
      mode    <= MODE_IDLE;
    end else begin
      enabled <= nEnabled;
      paused  <= nPaused;
      mode    <= nMode;
    end
  end

  assign busy      = (mode != MODE_IDLE);
  assign acceptEn  = enabled && !paused && (mode == MODE_IDLE);
  assign respondEn = enabled && !paused && (mode != MODE_INVAL);

endmodule

// File: rtl/ccu_data.sv
module ccu_data
  import ccu_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccu_strobe_t       stb,
  input  logic              reqTaken,
  input  logic              reqDone,
  output logic              cntZero,
  output logic              clearBuf,
  output logic              rspValid,
  output logic [KIND_W-1:0] rspKind,
  output logic              errFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt   <= '0;
      clearBuf <= 1'b0;
      rspValid <= 1'b0;
      rspKind  <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.cntClear)
        outCnt <= '0;
      else if (reqTaken && !reqDone)
        outCnt <= outCnt + CNT_ONE;
      else if (reqDone && !reqTaken)
        outCnt <= outCnt - CNT_ONE;
      clearBuf <= stb.clrStart;
      rspValid <= stb.rspFire;
      if (stb.rspFire) rspKind <= stb.rspKind;
      if (stb.errSet)  errFlag <= 1'b1;
    end
  end

  assign cntZero = (outCnt == '0);

endmodule

// File: rtl/comp_ctrl_unit.sv
module comp_ctrl_unit
  import ccu_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [2:0]  cmdAct,
  input  logic        reqTaken,
  input  logic        reqDone,
  input  logic        flushDone,
  output logic        acceptEn,
  output logic        respondEn,
  output logic        clearBuf,
  output logic        rspValid,
  output logic [2:0]  rspKind,
  output logic        errFlag
);

  ccu_dec_t    dec;
  ccu_strobe_t stb;
  logic        enabled, busy, cntZero;

  ccu_decode u_dec (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdAct   (cmdAct),
    .enabled  (enabled),
    .busy     (busy),
    .dec      (dec)
  );

  ccu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dec       (dec),
    .cntZero   (cntZero),
    .flushDone (flushDone),
    .enabled   (enabled),
    .busy      (busy),
    .acceptEn  (acceptEn),
    .respondEn (respondEn),
    .stb       (stb)
  );

  ccu_data #(.CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqTaken  (reqTaken),
    .reqDone   (reqDone),
    .cntZero   (cntZero),
    .clearBuf  (clearBuf),
    .rspValid  (rspValid),
    .rspKind   (rspKind),
    .errFlag   (errFlag)
  );

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       acceptEn,
  input logic       respondEn,
  input logic       clearBuf,
  input logic       rspValid,
  input logic [2:0] rspKind,
  input logic       errFlag
);

  // R4: intake never open while responses are blocked
  a_r4_accept_needs_respond: assert property (@(posedge clk) disable iff (!rstN)
    acceptEn |-> respondEn);

  // R7: buffer clear lasts one cycle
  a_r7_clear_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    clearBuf |=> !clearBuf);

  // R7: intake and responses closed while clearing
  a_r7_clear_gates: assert property (@(posedge clk) disable iff (!rstN)
    clearBuf |-> (!acceptEn && !respondEn));

  // R7: invalidate response follows the clear pulse
  a_r7_inval_rsp: assert property (@(posedge clk) disable iff (!rstN)
    clearBuf |=> (rspValid && rspKind == 3'd6));

  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R5: intake was closed in the cycle before a drain response
  a_r5_drain_closed: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd4) |-> !$past(acceptEn));

  // R2: after an enable response the component is open
  a_r2_enable_open: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd0) |-> (acceptEn && respondEn));

  // R3: after a disable response the component is closed
  a_r3_disable_closed: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd1) |-> (!acceptEn && !respondEn));

endmodule

bind comp_ctrl_unit ccu_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .acceptEn  (acceptEn),
  .respondEn (respondEn),
  .clearBuf  (clearBuf),
  .rspValid  (rspValid),
  .rspKind   (rspKind),
  .errFlag   (errFlag)
);

// File: tb/sim_comp_ctrl_unit.sv
`timescale 1ns/1ps
module sim_comp_ctrl_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [2:0] cmdAct = 3'd0;
  logic reqTaken = 1'b0, reqDone = 1'b0, flushDone = 1'b0;
  logic acceptEn, respondEn, clearBuf, rspValid, errFlag;
  logic [2:0] rspKind;

  always #2 clk = ~clk;  // 250 MHz

  comp_ctrl_unit u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAct(cmdAct),
    .reqTaken(reqTaken), .reqDone(reqDone), .flushDone(flushDone),
    .acceptEn(acceptEn), .respondEn(respondEn), .clearBuf(clearBuf),
    .rspValid(rspValid), .rspKind(rspKind), .errFlag(errFlag)
  );

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;

  // reference model state
  bit mEn, mPa, mClr, mRspV, mErr;
  int mMode;   // 0 idle 1 drain 2 flush 3 inval
  int mCnt;
  int mKind;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      mEn = 0; mPa = 0; mMode = 0; mCnt = 0; mErr = 0; mClr = 0; mRspV = 0; mKind = 0;
    end else begin
      int oMode, oCnt;
      bit bad;
      oMode = mMode; oCnt = mCnt;
      mRspV = 0; mClr = 0; bad = 0;
      mCnt = oCnt + (reqTaken ? 1 : 0) - (reqDone ? 1 : 0);
      if (oMode == 1 && oCnt == 0) begin mRspV = 1; mKind = 4; mMode = 0; end
      if (oMode == 2 && flushDone) begin mRspV = 1; mKind = 5; mMode = 0; end
      if (oMode == 3) begin mRspV = 1; mKind = 6; mMode = 0; mCnt = 0; end
      if (cmdValid) begin
        if (oMode != 0) bad = 1;
        else if (!mEn) begin
          if (cmdOp == 0) begin mEn = 1; mPa = 0; mRspV = 1; mKind = 0; end
          else bad = 1;
        end else if (cmdOp == 1) begin mEn = 0; mPa = 0; mRspV = 1; mKind = 1; end
        else if (cmdOp == 2) begin mPa = 1; mRspV = 1; mKind = 2; end
        else if (cmdOp == 3) begin mPa = 0; mRspV = 1; mKind = 3; end
        else if (cmdOp == 4 && $countones(cmdAct) == 1) begin
          if (cmdAct[0]) mMode = 1;
          else if (cmdAct[1]) mMode = 2;
          else begin mMode = 3; mClr = 1; end
        end else bad = 1;
      end
      if (bad) mErr = 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R4 acceptEn", acceptEn, (mEn && !mPa && mMode == 0) ? 1 : 0);
      check("R4 respondEn", respondEn, (mEn && !mPa && mMode != 3) ? 1 : 0);
      check("R7 clearBuf", clearBuf, mClr);
      check("R5 rspValid", rspValid, mRspV);
      if (mRspV) check("R5 rspKind", rspKind, mKind);
      check("R10 errFlag", errFlag, mErr);
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [2:0] act);
    cmdValid = 1; cmdOp = op; cmdAct = act;
    @(negedge clk);
    cmdValid = 0; cmdOp = 0; cmdAct = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) reqTaken = 1; else if (which == 1) reqDone = 1; else flushDone = 1;
    @(negedge clk);
    reqTaken = 0; reqDone = 0; flushDone = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    doReset();
    // R1
    check("R1 acceptEn", acceptEn, 0);
    check("R1 respondEn", respondEn, 0);
    check("R1 rspValid", rspValid, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 clearBuf", clearBuf, 0);

    // R2 enable
    cmd(3'd0, 3'd0);
    check("R2 rspValid", rspValid, 1);
    check("R2 rspKind", rspKind, 0);
    check("R2 acceptEn", acceptEn, 1);
    pulse(0); pulse(0); pulse(0); pulse(1);   // count 2

    // R4 pause/resume
    cmd(3'd2, 3'd0);
    check("R4 paused acceptEn", acceptEn, 0);
    check("R4 paused respondEn", respondEn, 0);
    check("R4 pause rspKind", rspKind, 2);
    cmd(3'd3, 3'd0);
    check("R4 resume rspKind", rspKind, 3);
    check("R4 resumed acceptEn", acceptEn, 1);

    // R5 drain with two outstanding
    cmd(3'd4, 3'b001);
    check("R5 drain acceptEn", acceptEn, 0);
    check("R5 drain respondEn", respondEn, 1);
    check("R5 drain no early rsp", rspValid, 0);
    pulse(1); pulse(1);
    check("R5 not yet done", rspValid, 0);
    @(negedge clk);
    check("R5 drain rspValid", rspValid, 1);
    check("R5 drain rspKind", rspKind, 4);

    // R9 flush right after drain response, R6 flushDone
    cmd(3'd4, 3'b010);
    check("R9 flush accepted errFlag", errFlag, 0);
    check("R6 flush acceptEn", acceptEn, 0);
    pulse(2);
    check("R6 flush rspKind", rspKind, 5);
    check("R6 flush rspValid", rspValid, 1);
    pulse(2);
    check("R6 stray flushDone", rspValid, 0);
    check("R6 stray flushDone acceptEn", acceptEn, 1);

    // R7 invalidate with two outstanding, then drain completes at once
    pulse(0); pulse(0);
    cmd(3'd4, 3'b100);
    check("R7 clearBuf", clearBuf, 1);
    check("R7 respondEn", respondEn, 0);
    @(negedge clk);
    check("R7 clearBuf low", clearBuf, 0);
    check("R7 rspKind", rspKind, 6);
    cmd(3'd4, 3'b001);
    @(negedge clk);
    check("R7 count zeroed drain rsp", rspValid, 1);
    check("R7 count zeroed drain kind", rspKind, 4);

    // R3 disable
    cmd(3'd1, 3'd0);
    check("R3 disable rspKind", rspKind, 1);
    check("R3 disabled acceptEn", acceptEn, 0);
    check("R10 no error so far", errFlag, 0);

    // R3 command while disabled
    cmd(3'd2, 3'd0);
    check("R3 rejected rspValid", rspValid, 0);
    check("R3 rejected errFlag", errFlag, 1);
    repeat (3) @(negedge clk);
    check("R10 sticky", errFlag, 1);
    cmd(3'd0, 3'd0);
    check("R10 error stays after legal cmd", errFlag, 1);
    check("R3 enable still works", acceptEn, 1);

    // R2 double enable
    doReset();
    check("R10 reset clears", errFlag, 0);
    cmd(3'd0, 3'd0);
    cmd(3'd0, 3'd0);
    check("R2 re-enable error", errFlag, 1);
    check("R2 re-enable no rsp", rspValid, 0);

    // R8 drain with flush
    doReset();
    cmd(3'd0, 3'd0);
    cmd(3'd4, 3'b011);
    check("R8 error", errFlag, 1);
    check("R8 state unchanged", acceptEn, 1);
    check("R8 no rsp", rspValid, 0);

    // R2 unused opcode
    doReset();
    cmd(3'd0, 3'd0);
    cmd(3'd6, 3'd0);
    check("R2 unused opcode error", errFlag, 1);

    // R9 command during drain
    doReset();
    cmd(3'd0, 3'd0);
    pulse(0);
    cmd(3'd4, 3'b001);
    cmd(3'd4, 3'b010);
    check("R9 busy error", errFlag, 1);
    check("R9 busy no rsp", rspValid, 0);
    pulse(1);
    @(negedge clk);
    check("R9 drain still ends", rspKind, 4);
    check("R9 drain rspValid", rspValid, 1);
    cmd(3'd2, 3'd0);
    check("R9 idle again pause", rspKind, 2);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule